// File: doc/BRIEF.md
# Three-Class Interrupt Entry and Return Controller

This block sits beside the fetch stage of a processor core. It decides when an interrupt is taken, for three classes: debug, critical and noncritical. In the cycle it takes one, it saves a return address and the current status word into the save pair that belongs to that class. It also writes back a status word with the class's enable bits cleared. Fetch is redirected to the vector named by the class code. When the decoded return instruction of a class arrives, the block hands back the saved address and status word in the same cycle.

A configuration input selects how debug is handled. With the input high, debug has its own save pair and its own return instruction. With it low, debug shares the critical pair and is returned through the critical return. In that case the debug return raises an illegal-instruction flag, and the per-class controls that decide whether an entry clears the debug-enable bit are ignored and read as set. All interfaces are plain control and status pins. There is no valid/ready handshake, because every request is a held level and every response lasts a single cycle.

Top module: `irq_entry_ctrl`

## Requirements
- R1: With several requests pending and unmasked, at most one take is issued per cycle, with debug above critical above noncritical. `take_cls` reads 0 for noncritical, 1 for critical and 2 for debug. A request that loses stays pending, and it is taken in a later cycle once it wins.
- R2: A noncritical request marked asynchronous is masked when the external-enable bit of `status_in` (bit 15) is low. A synchronous noncritical request is never masked. A critical request is masked by the critical-enable bit (bit 17), and a debug request by the debug-enable bit (bit 9).
- R3: On a take, the chosen pair stores `status_in` and an address: `next_pc` when `resume_next` is high, otherwise `cur_pc`. The store happens at the clock edge that ends the take cycle.
- R4: In a take cycle `status_wr` is high and `status_out` equals `status_in` with bit 15 cleared. A critical or debug take also clears bit 17, and a debug take also clears bit 9.
- R5: With `dbg_cfg_en` low, a debug take saves into the critical pair. With it high, a debug take saves into the debug pair and leaves the critical pair unchanged.
- R6: A return strobe raises `restore` and `status_wr` in the same cycle, with `restore_pc` and `status_out` taken from the pair of that class. If several strobes arrive together, debug wins over critical, which wins over noncritical.
- R7: With `dbg_cfg_en` low, `ret_dbg` raises `illegal_op` for that cycle and causes neither a restore nor a status write.
- R8: With `dbg_cfg_en` high, a noncritical take clears bit 9 only when `clr_de_ctl[0]` is set, and a critical take only when `clr_de_ctl[1]` is set. With `dbg_cfg_en` low, both controls are read as 1.
- R9: In a cycle with any return strobe, no take is issued. A request held through that cycle is taken afterwards.
- R10: A pair keeps its contents except in a cycle that writes it, so a critical take nested inside a noncritical handler leaves the noncritical pair intact.
- R11: After reset all pairs hold zero and, with no stimulus, `take`, `restore`, `status_wr` and `illegal_op` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_cfg_en | input | 1 | Debug has its own save pair and return when high |
| clr_de_ctl | input | 2 | Bit 0: noncritical take clears debug enable; bit 1: the same for a critical take |
| dbg_req | input | 1 | Debug request pending |
| crit_req | input | 1 | Critical request pending |
| nc_req | input | 1 | Noncritical request pending |
| nc_async | input | 1 | The noncritical request is asynchronous and can be masked |
| resume_next | input | 1 | Save `next_pc` instead of `cur_pc` |
| cur_pc | input | AW | Address of the current instruction |
| next_pc | input | AW | Address of the instruction after it |
| status_in | input | SW | Current status word |
| ret_nc | input | 1 | Noncritical return decoded |
| ret_crit | input | 1 | Critical return decoded |
| ret_dbg | input | 1 | Debug return decoded |
| take | output | 1 | Interrupt taken this cycle; redirect fetch |
| take_cls | output | 2 | Vector select: 0 noncritical, 1 critical, 2 debug |
| status_wr | output | 1 | Load `status_out` into the status word |
| status_out | output | SW | New status word on a take or a restore |
| restore | output | 1 | Return accepted; redirect fetch to `restore_pc` |
| restore_pc | output | AW | Saved return address |
| illegal_op | output | 1 | Debug return while debug shares the critical pair |

## Verification
A wrong internal state shows up in the pairs, and the pairs can only be seen at the ports through a return. A save into the wrong pair, or a missed save, therefore shows up as a wrong `restore_pc` or `status_out` on the first return strobe of the affected class. It does not show up at the take itself. For that reason the nested and shared-debug sequences each end with returns that read back every pair they could have touched. Errors in arbitration, masking and clearing show up combinationally, on `take`, `take_cls` and `status_out`, in the very cycle the request is presented.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    CLS_NC   = 2'd0,
    CLS_CRIT = 2'd1,
    CLS_DBG  = 2'd2
  } irq_cls_e;

  localparam int NUM_CLS = 3;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic     dbg_req,
  input  logic     crit_req,
  input  logic     nc_req,
  input  logic     nc_async,
  input  logic     ee,
  input  logic     ce,
  input  logic     de,
  input  logic     hold,
  output logic     take,
  output irq_cls_e cls
);
  logic d_ok, c_ok, n_ok;

  always_comb begin
    d_ok = dbg_req & de;
    c_ok = crit_req & ce;
    n_ok = nc_req & (ee | ~nc_async);
    take = 1'b0;
    cls  = CLS_NC;
    if (!hold) begin
      if (d_ok) begin
        take = 1'b1;
        cls  = CLS_DBG;
      end else if (c_ok) begin
        take = 1'b1;
        cls  = CLS_CRIT;
      end else if (n_ok) begin
        take = 1'b1;
        cls  = CLS_NC;
      end
    end
  end
endmodule

// File: rtl/irq_save_pair.sv
module irq_save_pair #(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] pc_d,
  input  logic [SW-1:0] st_d,
  output logic [AW-1:0] pc_q,
  output logic [SW-1:0] st_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      st_q <= '0;
    end else if (wr_en) begin
      pc_q <= pc_d;
      st_q <= st_d;
    end
  end

  assert_pair_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pc_q) && $stable(st_q)));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SW     = 32,
  parameter int EE_BIT = 15,
  parameter int CE_BIT = 17,
  parameter int DE_BIT = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_cfg_en,
  input  logic [1:0]    clr_de_ctl,
  input  logic          dbg_req,
  input  logic          crit_req,
  input  logic          nc_req,
  input  logic          nc_async,
  input  logic          resume_next,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] next_pc,
  input  logic [SW-1:0] status_in,
  input  logic          ret_nc,
  input  logic          ret_crit,
  input  logic          ret_dbg,
  output logic          take,
  output logic [1:0]    take_cls,
  output logic          status_wr,
  output logic [SW-1:0] status_out,
  output logic          restore,
  output logic [AW-1:0] restore_pc,
  output logic          illegal_op
);
  localparam logic [SW-1:0] EE_M = SW'(1) << EE_BIT;
  localparam logic [SW-1:0] CE_M = SW'(1) << CE_BIT;
  localparam logic [SW-1:0] DE_M = SW'(1) << DE_BIT;

  irq_cls_e      cls, dest, src;
  logic          any_ret;
  logic [1:0]    eff_ctl;
  logic [AW-1:0] save_pc;
  logic [SW-1:0] entry_st, clr_m;
  logic [NUM_CLS-1:0] wr_en;
  logic [AW-1:0] pc_q [NUM_CLS];
  logic [SW-1:0] st_q [NUM_CLS];

  assign any_ret = ret_nc | ret_crit | ret_dbg;

  irq_arbiter u_arb (
    .dbg_req  (dbg_req),
    .crit_req (crit_req),
    .nc_req   (nc_req),
    .nc_async (nc_async),
    .ee       (status_in[EE_BIT]),
    .ce       (status_in[CE_BIT]),
    .de       (status_in[DE_BIT]),
    .hold     (any_ret),
    .take     (take),
    .cls      (cls)
  );

  assign take_cls = cls;
  assign dest     = (cls == CLS_DBG && !dbg_cfg_en) ? CLS_CRIT : cls;
  assign save_pc  = resume_next ? next_pc : cur_pc;
  assign eff_ctl  = dbg_cfg_en ? clr_de_ctl : 2'b11;

  always_comb begin
    clr_m = EE_M;
    unique case (cls)
      CLS_DBG:  clr_m = EE_M | CE_M | DE_M;
      CLS_CRIT: clr_m = EE_M | CE_M | (eff_ctl[1] ? DE_M : '0);
      default:  clr_m = EE_M | (eff_ctl[0] ? DE_M : '0);
    endcase
    entry_st = status_in & ~clr_m;
  end

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_pair
    localparam logic [1:0] KC = 2'(k);
    assign wr_en[k] = take && (dest == irq_cls_e'(KC));
    irq_save_pair #(.AW(AW), .SW(SW)) u_pair (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en[k]),
      .pc_d  (save_pc),
      .st_d  (status_in),
      .pc_q  (pc_q[k]),
      .st_q  (st_q[k])
    );
  end

  always_comb begin
    restore    = 1'b0;
    illegal_op = 1'b0;
    src        = CLS_NC;
    if (ret_dbg) begin
      if (dbg_cfg_en) begin
        restore = 1'b1;
        src     = CLS_DBG;
      end else begin
        illegal_op = 1'b1;
      end
    end else if (ret_crit) begin
      restore = 1'b1;
      src     = CLS_CRIT;
    end else if (ret_nc) begin
      restore = 1'b1;
    end
  end

  always_comb begin
    status_wr  = restore | take;
    restore_pc = restore ? pc_q[src] : '0;
    if (restore)   status_out = st_q[src];
    else if (take) status_out = entry_st;
    else           status_out = '0;
  end

  assert_one_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  assert_ret_blocks_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_ret |-> !take);
  assert_illegal_no_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (!restore && !status_wr));
  assert_ee_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !restore) |-> !status_out[EE_BIT]);
  assert_dbg_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_cls == 2'd2 && !dbg_cfg_en) |=> (pc_q[CLS_CRIT] == $past(save_pc)));
endmodule

// File: tb/irq_entry_ctrl_test.sv
module irq_entry_ctrl_test;
  localparam int EE = 32'h0000_8000;
  localparam int CE = 32'h0002_0000;
  localparam int DE = 32'h0000_0200;
  localparam logic [31:0] M = 32'h0002_8201;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dbg_cfg_en = 1'b1;
  logic [1:0] clr_de_ctl = 2'b00;
  logic dbg_req = 0, crit_req = 0, nc_req = 0, nc_async = 0, resume_next = 0;
  logic [31:0] cur_pc = 0, next_pc = 0, status_in = 0;
  logic ret_nc = 0, ret_crit = 0, ret_dbg = 0;
  logic take, status_wr, restore, illegal_op;
  logic [1:0] take_cls;
  logic [31:0] status_out, restore_pc;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_entry_ctrl uut (.*);

  // fields: dbg crit nc async ee ce de | exp_take exp_cls[1:0]
  localparam logic [9:0] VEC [10] = '{
    10'b0011100100, 10'b0011000000, 10'b0010000100, 10'b0100010101,
    10'b0100000000, 10'b1000001110, 10'b1000000000, 10'b1111111110,
    10'b0111110101, 10'b1100010101
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    dbg_req = 0; crit_req = 0; nc_req = 0; nc_async = 0; resume_next = 0;
    ret_nc = 0; ret_crit = 0; ret_dbg = 0;
  endtask

  task automatic settle();
    #5;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();
    // R11 reset state
    chk("R11 take", take, 0); chk("R11 restore", restore, 0);
    chk("R11 status_wr", status_wr, 0); chk("R11 illegal", illegal_op, 0);
    @(negedge clk) ret_nc = 1; settle();
    chk("R11 nc pair pc", restore_pc, 0); chk("R11 nc pair st", status_out, 0);

    // R1 R2 vector table
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      idle();
      {dbg_req, crit_req, nc_req, nc_async} = VEC[i][9:6];
      status_in = (VEC[i][5] ? EE : 0) | (VEC[i][4] ? CE : 0) | (VEC[i][3] ? DE : 0);
      settle();
      chk("R1/R2 take", take, VEC[i][2]);
      if (VEC[i][2]) chk("R1 cls", take_cls, VEC[i][1:0]);
    end

    // noncritical take, R3 R4
    @(negedge clk) idle(); nc_req = 1; nc_async = 1; status_in = M;
    cur_pc = 32'h100; next_pc = 32'h104; settle();
    chk("R4 nc take", take, 1); chk("R4 nc status", status_out, 32'h0002_0201);
    // nested critical, R10
    @(negedge clk) idle(); crit_req = 1; resume_next = 1; status_in = 32'h0002_0201;
    cur_pc = 32'h200; next_pc = 32'h204; settle();
    chk("R4 crit cls", take_cls, 1); chk("R4 crit status", status_out, 32'h0000_0201);
    @(negedge clk) idle(); ret_crit = 1; settle();
    chk("R6 restore", restore, 1); chk("R3 crit pc", restore_pc, 32'h204);
    chk("R6 crit st", status_out, 32'h0002_0201);
    @(negedge clk) idle(); ret_nc = 1; nc_req = 1; settle();
    chk("R9 no take", take, 0); chk("R10 nc pc", restore_pc, 32'h100);
    chk("R10 nc st", status_out, M);
    @(negedge clk) ret_nc = 0; nc_async = 0; settle();
    chk("R9 pending taken", take, 1);

    // shared debug, R5 R7
    @(negedge clk) idle(); dbg_cfg_en = 0; dbg_req = 1; status_in = M; cur_pc = 32'h300; settle();
    chk("R4 dbg cls", take_cls, 2); chk("R4 dbg status", status_out, 32'h1);
    @(negedge clk) idle(); ret_dbg = 1; settle();
    chk("R7 illegal", illegal_op, 1); chk("R7 no restore", restore, 0);
    chk("R7 no status wr", status_wr, 0);
    @(negedge clk) idle(); ret_crit = 1; settle();
    chk("R5 shared pc", restore_pc, 32'h300);

    // own debug pair, R5
    @(negedge clk) idle(); dbg_cfg_en = 1; dbg_req = 1; cur_pc = 32'h400; settle();
    chk("R5 dbg take", take, 1);
    @(negedge clk) idle(); ret_dbg = 1; settle();
    chk("R6 dbg pc", restore_pc, 32'h400); chk("R7 legal", illegal_op, 0);
    chk("R6 dbg st", status_out, M);
    @(negedge clk) idle(); ret_crit = 1; settle();
    chk("R5 crit untouched", restore_pc, 32'h300);
    @(negedge clk) idle(); ret_crit = 1; ret_nc = 1; ret_dbg = 1; settle();
    chk("R6 ret priority", restore_pc, 32'h400);

    // R8 clear controls
    @(negedge clk) idle(); dbg_cfg_en = 0; clr_de_ctl = 2'b00; nc_req = 1; settle();
    chk("R8 forced clear", status_out, 32'h0002_0001);
    @(negedge clk) idle(); dbg_cfg_en = 1; clr_de_ctl = 2'b00; nc_req = 1; settle();
    chk("R8 no clear", status_out, 32'h0002_0201);
    @(negedge clk) idle(); clr_de_ctl = 2'b10; crit_req = 1; settle();
    chk("R8 crit clear", status_out, 32'h1);

    // R1 loser stays pending
    @(negedge clk) idle(); clr_de_ctl = 2'b00; dbg_req = 1; crit_req = 1; status_in = M; settle();
    chk("R1 dbg first", take_cls, 2);
    @(negedge clk) status_in = M & ~DE; settle();
    chk("R1 crit later", take_cls, 1); chk("R1 crit take", take, 1);

    @(negedge clk) idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule